// File: doc/BRIEF.md
# Mask-Driven Element Sequence Generator

This unit fills a destination vector one element per cycle. In prefix-count mode, each element receives how many enabled, set source-mask bits sit below it. In index mode, each element receives its own position. The element width is chosen per operation as 1, 2, 4 or 8 bytes. Each produced value is cut down to that width.

A caller presents the operation on its inputs and pulses `start`. The inputs are the mode, the element width in bytes, the vector length, the source mask, the enable mask and the current destination contents. The unit captures all of them in that cycle. It then streams `(wr_idx, wr_data)` writes in ascending order. An element whose enable bit is clear is rewritten with its old contents. `done` marks the end of the operation. An unsupported width ends the operation at once, with no writes and with `width_err` raised.

The running count is kept at 64 bits. Narrowing to the element width happens only at the output.

Top module: `mask_seq_gen`

## Requirements
- R1: `elem_bytes` values 1, 2, 4 and 8 are legal. Any other value produces no write. In that case `done` and `width_err` are high together for exactly one cycle, in the second cycle after the accepting clock edge.
- R2: In prefix-count mode (`mode_index`=0), an enabled element k receives the number of indices j<k where both `en_mask[j]` and `src_mask[j]` are 1.
- R3: In index mode (`mode_index`=1), an enabled element k receives k, whatever the source mask holds.
- R4: `wr_data` keeps only the low 8×`elem_bytes` bits of the value, and its upper bits are zero.
- R5: A disabled element k (`en_mask[k]`=0) is written with `old_elems[64k+63:64k]` narrowed per R4. Its source bit never advances the prefix count.
- R6: Writes appear one per cycle with `wr_valid` high, starting at index 0 in the cycle after acceptance and rising by one each cycle. After reset all outputs are low.
- R7: `done` pulses for one cycle, in the cycle after the last write. When the vector length is 0, it pulses in the cycle after acceptance with no write.
- R8: `start` and every other input are ignored from the cycle after acceptance until `done` is high.
- R9: A `vec_len` larger than MAX_ELEMS is treated as MAX_ELEMS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept an operation when idle |
| mode_index | input | 1 | 0 = prefix count, 1 = element index |
| elem_bytes | input | 4 | Element width in bytes |
| vec_len | input | LEN_W | Number of elements to write |
| src_mask | input | MAX_ELEMS | Source mask, bit k for element k |
| en_mask | input | MAX_ELEMS | Enable mask, bit k for element k |
| old_elems | input | 64×MAX_ELEMS | Current destination elements, element k at bits 64k+63:64k |
| wr_valid | output | 1 | Element write strobe |
| wr_idx | output | log2(MAX_ELEMS) | Index of the written element |
| wr_data | output | 64 | Value written, narrowed to the element width |
| done | output | 1 | One-cycle completion pulse |
| width_err | output | 1 | Unsupported width, pulses with `done` |

## Verification
The hardest case to reach is a second request that arrives while a stream is still running. It must neither restart the stream nor change the stream's values. The bench reaches it by pulsing `start` one cycle into a run. In the same cycle it inverts both masks, flips the mode and shrinks the length, and the remaining writes must still match the first request. Disabled elements with set source bits are mixed into prefix-count runs, which shows that they never reach the counter. Narrowing is exercised with wide old values at 1-byte width.

// File: rtl/mask_seq_pkg.sv
package mask_seq_pkg;
    localparam int VAL_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mseq_width_dec.sv
module mseq_width_dec
    import mask_seq_pkg::*;
(
    input  logic [3:0]       elem_bytes,
    output logic             legal,
    output logic [VAL_W-1:0] keep_mask
);
    always_comb begin
        legal     = 1'b1;
        keep_mask = '0;
        case (elem_bytes)
            4'd1:    keep_mask = 64'h0000_0000_0000_00FF;
            4'd2:    keep_mask = 64'h0000_0000_0000_FFFF;
            4'd4:    keep_mask = 64'h0000_0000_FFFF_FFFF;
            4'd8:    keep_mask = '1;
            default: legal     = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_elem_pick.sv
module mseq_elem_pick
    import mask_seq_pkg::*;
#(
    parameter int MAX_ELEMS = 16,
    localparam int IDX_W = $clog2(MAX_ELEMS)
) (
    input  logic [IDX_W-1:0]           idx,
    input  logic [MAX_ELEMS-1:0]       src_bits,
    input  logic [MAX_ELEMS-1:0]       en_bits,
    input  logic [MAX_ELEMS*VAL_W-1:0] old_flat,
    output logic                       src_bit,
    output logic                       en_bit,
    output logic [VAL_W-1:0]           old_val
);
    logic [VAL_W-1:0] old_arr [MAX_ELEMS];

    for (genvar g = 0; g < MAX_ELEMS; g++) begin : g_split
        assign old_arr[g] = old_flat[g*VAL_W +: VAL_W];
    end

    assign src_bit = src_bits[idx];
    assign en_bit  = en_bits[idx];
    assign old_val = old_arr[idx];
endmodule

// File: rtl/mask_seq_gen.sv
module mask_seq_gen
    import mask_seq_pkg::*;
#(
    parameter int MAX_ELEMS = 16,
    parameter int LEN_W     = 6,
    localparam int IDX_W    = $clog2(MAX_ELEMS),
    localparam int OLD_W    = MAX_ELEMS * VAL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode_index,
    input  logic [3:0]           elem_bytes,
    input  logic [LEN_W-1:0]     vec_len,
    input  logic [MAX_ELEMS-1:0] src_mask,
    input  logic [MAX_ELEMS-1:0] en_mask,
    input  logic [OLD_W-1:0]     old_elems,
    output logic                 wr_valid,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [VAL_W-1:0]     wr_data,
    output logic                 done,
    output logic                 width_err
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_ELEMS);

    typedef struct packed {
        seq_state_e           st;
        logic                 mode;
        logic [3:0]           bytes;
        logic [IDX_W-1:0]     last;
        logic [IDX_W-1:0]     idx;
        logic [VAL_W-1:0]     cnt;
        logic                 err;
        logic [MAX_ELEMS-1:0] src;
        logic [MAX_ELEMS-1:0] en;
        logic [OLD_W-1:0]     old;
        logic                 wv;
        logic [IDX_W-1:0]     widx;
        logic [VAL_W-1:0]     wdata;
        logic                 dn;
        logic                 ill;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [3:0]       dec_bytes;
    logic             dec_legal;
    logic [VAL_W-1:0] dec_mask;
    logic             pick_src, pick_en;
    logic [VAL_W-1:0] pick_old;
    logic [LEN_W-1:0] eff_len;

    // One decoder: checks the requested width while idle, narrows values while running.
    assign dec_bytes = (ctl_q.st == ST_IDLE) ? elem_bytes : ctl_q.bytes;
    assign eff_len   = (vec_len > MAX_LEN) ? MAX_LEN : vec_len;

    mseq_width_dec u_dec (
        .elem_bytes (dec_bytes),
        .legal      (dec_legal),
        .keep_mask  (dec_mask)
    );

    mseq_elem_pick #(.MAX_ELEMS(MAX_ELEMS)) u_pick (
        .idx      (ctl_q.idx),
        .src_bits (ctl_q.src),
        .en_bits  (ctl_q.en),
        .old_flat (ctl_q.old),
        .src_bit  (pick_src),
        .en_bit   (pick_en),
        .old_val  (pick_old)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.wv = 1'b0;
        ctl_d.dn = 1'b0;
        ctl_d.ill = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.mode  = mode_index;
                    ctl_d.bytes = elem_bytes;
                    ctl_d.src   = src_mask;
                    ctl_d.en    = en_mask;
                    ctl_d.old   = old_elems;
                    ctl_d.idx   = '0;
                    ctl_d.cnt   = '0;
                    ctl_d.err   = !dec_legal;
                    ctl_d.last  = IDX_W'(eff_len - 1'b1);
                    ctl_d.st    = (!dec_legal || eff_len == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                ctl_d.wv   = 1'b1;
                ctl_d.widx = ctl_q.idx;
                if (pick_en)
                    ctl_d.wdata = (ctl_q.mode ? VAL_W'(ctl_q.idx) : ctl_q.cnt) & dec_mask;
                else
                    ctl_d.wdata = pick_old & dec_mask;
                if (!ctl_q.mode && pick_en && pick_src)
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                ctl_d.idx = ctl_q.idx + 1'b1;
                if (ctl_q.idx == ctl_q.last)
                    ctl_d.st = ST_FIN;
            end
            ST_FIN: begin
                ctl_d.dn  = 1'b1;
                ctl_d.ill = ctl_q.err;
                ctl_d.st  = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wr_valid  = ctl_q.wv;
    assign wr_idx    = ctl_q.widx;
    assign wr_data   = ctl_q.wdata;
    assign done      = ctl_q.dn;
    assign width_err = ctl_q.ill;

    // R7
    no_wr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && done));

    // R1
    err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |-> done);

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_idx == $past(wr_idx) + 1'b1));

    // R6
    first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> (wr_idx == '0));

    // R4
    narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data & ~dec_mask) == '0));

    // R2
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && $past(ctl_q.st == ST_RUN)) |-> (ctl_q.cnt >= $past(ctl_q.cnt)));
endmodule

// File: tb/mask_seq_gen_bench.sv
module mask_seq_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 16;
    localparam int LW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode_index = 1'b0;
    logic [3:0] elem_bytes = 4'd1;
    logic [LW-1:0] vec_len = '0;
    logic [NE-1:0] src_mask = '0;
    logic [NE-1:0] en_mask = '0;
    logic [NE*64-1:0] old_elems = '0;
    logic wr_valid;
    logic [3:0] wr_idx;
    logic [63:0] wr_data;
    logic done;
    logic width_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] old_ref [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_seq_gen #(.MAX_ELEMS(NE), .LEN_W(LW)) u_mask_seq_gen (
        .clk, .rst_n, .start, .mode_index, .elem_bytes, .vec_len,
        .src_mask, .en_mask, .old_elems,
        .wr_valid, .wr_idx, .wr_data, .done, .width_err
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_old(input logic [63:0] base);
        for (int k = 0; k < NE; k++) begin
            old_ref[k] = base ^ (64'h0101_0101_0101_0101 * 64'(k + 1));
            old_elems[k*64 +: 64] = old_ref[k];
        end
    endtask

    task automatic run_op(input bit md, input int bytes, input int len,
                          input logic [NE-1:0] src, input logic [NE-1:0] en,
                          input bit disturb, input string req);
        bit legal = (bytes == 1 || bytes == 2 || bytes == 4 || bytes == 8);
        logic [63:0] msk = !legal ? 64'd0 : (bytes == 8) ? '1 : ((64'd1 << (8*bytes)) - 1);
        int n = (len > NE) ? NE : len;
        longint unsigned cnt = 0;
        logic [63:0] exp;
        @(negedge clk);
        start = 1'b1; mode_index = md; elem_bytes = 4'(bytes);
        vec_len = LW'(len); src_mask = src; en_mask = en;
        @(negedge clk);
        start = 1'b0;
        if (!legal || n == 0) begin
            @(negedge clk);
            // R1 / R7: immediate completion
            chk(done && !wr_valid && (width_err == !legal), req,
                {61'd0, done, wr_valid, width_err}, {61'd0, 1'b1, 1'b0, !legal});
        end else begin
            for (int k = 0; k < n; k++) begin
                @(negedge clk);
                if (en[k]) exp = (md ? 64'(k) : 64'(cnt)) & msk;
                else       exp = old_ref[k] & msk;
                if (!md && en[k] && src[k]) cnt++;
                chk(wr_valid && wr_idx == 4'(k) && wr_data == exp && !done, req,
                    wr_data, exp);
                chk(wr_valid && wr_idx == 4'(k), {req, " R6 order"},
                    {59'd0, wr_valid, wr_idx}, {59'd0, 1'b1, 4'(k)});
                if (disturb && k == 0) begin
                    // R8: second request while busy
                    start = 1'b1; src_mask = ~src; en_mask = ~en;
                    mode_index = ~md; vec_len = LW'(3); elem_bytes = 4'd1;
                end
                if (disturb && k == 1) start = 1'b0;
            end
            @(negedge clk);
            // R7: done after last write
            chk(done && !wr_valid && !width_err, "R7 done",
                {61'd0, done, wr_valid, width_err}, {61'd0, 3'b100});
        end
        @(negedge clk);
        chk(!done && !wr_valid && !width_err, "R7 pulse width",
            {61'd0, done, wr_valid, width_err}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        load_old(64'hFEDC_BA98_7654_3210);
        repeat (3) @(negedge clk);
        // R6: reset state
        chk(!wr_valid && !done && !width_err, "R6 reset",
            {61'd0, wr_valid, done, width_err}, 64'd0);
        rst_n = 1'b1;
        // R2: all enabled, all set
        run_op(1'b0, 1, 16, 16'hFFFF, 16'hFFFF, 1'b0, "R2");
        // R2 R5: mixed masks, old values kept
        run_op(1'b0, 8, 13, 16'hA5C3, 16'h7BDE, 1'b0, "R2 R5");
        // R3 R5: index mode with gaps
        run_op(1'b1, 2, 10, 16'h0F0F, 16'hFDB7, 1'b0, "R3 R5");
        run_op(1'b1, 4, 16, 16'h0000, 16'hFFFF, 1'b0, "R3");
        // R4: wide old values narrowed to one byte
        run_op(1'b0, 1, 16, 16'hFFFF, 16'h5555, 1'b0, "R4");
        // R5: disabled set bits do not count
        run_op(1'b0, 8, 16, 16'hFFFF, 16'h8001, 1'b0, "R5");
        // R1: illegal widths
        run_op(1'b0, 3, 8, 16'hFFFF, 16'hFFFF, 1'b0, "R1");
        run_op(1'b1, 0, 8, 16'hFFFF, 16'hFFFF, 1'b0, "R1");
        run_op(1'b0, 9, 8, 16'hFFFF, 16'hFFFF, 1'b0, "R1");
        // R7: zero length, single element
        run_op(1'b0, 4, 0, 16'hFFFF, 16'hFFFF, 1'b0, "R7");
        run_op(1'b0, 2, 1, 16'h0001, 16'h0001, 1'b0, "R7");
        // R8: start ignored while busy
        load_old(64'h0123_4567_89AB_CDEF);
        run_op(1'b0, 4, 8, 16'h00B6, 16'h00ED, 1'b1, "R8");
        // R9: length above capacity
        run_op(1'b1, 8, 20, 16'h1234, 16'hFFFF, 1'b0, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule